// File: doc/BRIEF.md
# Grouped Page Bank Select Unit

This unit keeps the bank selection for a processor address space divided into sixteen pages. The page number is the top four bits of the fetch address. Pages are gathered into switching groups, and each group holds its own 2-bit bank code. Pages 0x0 to 0x2 never switch. Pages 0x4, 0x6 and 0x7 each form a group of one page. Port pages are linked in even/odd pairs. Page 0x5 shares a group with page 0x3, but page 0x3 always reads the first bank.

When a bank-enable opcode is fetched, the state of the group that owns the fetching page is updated. Other groups keep their state. For every access the unit returns the bank code of the addressed page. It also returns the fetch address extended at the top by that code, which a memory decoder can use directly. A deep-sleep request returns every group to the first bank.

Top module: `gbank_select`

## Requirements
- R1: The page is `fetch_addr[15:12]`. Pages 0x0, 0x1 and 0x2 always read code 00, which means bank 1. A bank-enable fetched from one of these pages changes no group.
- R2: Page 0x3 always reads 00. A bank-enable fetched from page 0x3 or from page 0x5 sets the bank of page 0x5.
- R3: Pages 0x4, 0x6 and 0x7 each hold their own bank. A bank-enable fetched from one of them changes only that page.
- R4: Pages 0x8/0x9, 0xA/0xB, 0xC/0xD and 0xE/0xF are linked pairs. A bank-enable fetched from either page of a pair sets the bank of both pages.
- R5: With `op_valid` high, the 10-bit opcode 0x100 selects code 00, 0x180 selects 01, 0x140 selects 10 and 0x1C0 selects 11. Any other opcode changes nothing, and so does any cycle with `op_valid` low.
- R6: An update changes at most one group. All other groups keep their codes.
- R7: A bank change appears from the cycle after the opcode cycle. During the opcode cycle the output still shows the old code.
- R8: `sleep_req` high at a clock edge sets every group to 00. It takes priority over a bank-enable in the same cycle.
- R9: Synchronous active-high `rst` sets every group to 00.
- R10: `bank_idx` is the code of the addressed page. `bank_addr` equals `{bank_idx, fetch_addr}`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| fetch_addr | input | 16 | Fetch address: page in the top 4 bits, offset below |
| op_valid | input | 1 | Opcode strobe for the fetch in this cycle |
| op_code | input | 10 | Fetched opcode |
| sleep_req | input | 1 | Deep-sleep entry; returns all groups to bank 1 |
| bank_idx | output | 2 | Bank code of the addressed page (00 = bank 1) |
| bank_addr | output | 18 | Bank code followed by the fetch address |

## Verification
The hardest case to reach is the asymmetric link between pages 0x3 and 0x5. Page 0x3 must trigger a switch that it never sees itself. The bench fetches a bank-enable from page 0x3 and then reads both pages 0x3 and 0x5. It then repeats the check with the enable fetched from page 0x5. Independence is hard to observe through a single-page output. To show it, the bench first loads every group with a different code and then sweeps all sixteen pages after each update. Sleep priority is checked by raising `sleep_req` in the same cycle as a valid bank-enable.

// File: rtl/gbank_pkg.sv
package gbank_pkg;

    localparam int PAGE_W   = 4;
    localparam int BANK_W   = 2;
    localparam int N_GRP    = 8;
    localparam int GRP_W    = $clog2(N_GRP);
    localparam int OP_W     = 10;
    localparam int PORT_GRP = 4;

    typedef logic [BANK_W-1:0] bank_t;
    typedef logic [PAGE_W-1:0] page_t;

    typedef enum logic [GRP_W-1:0] {
        GRP_P35 = 3'd0,
        GRP_P4  = 3'd1,
        GRP_P6  = 3'd2,
        GRP_P7  = 3'd3,
        GRP_P89 = 3'd4,
        GRP_PAB = 3'd5,
        GRP_PCD = 3'd6,
        GRP_PEF = 3'd7
    } grp_e;

    typedef struct packed {
        logic can_switch;
        grp_e grp;
        logic read_base;
    } page_map_t;

    typedef struct packed {
        logic  hit;
        bank_t code;
    } op_dec_t;

    localparam logic [OP_W-1:0] OP_MASK = 10'h33F;
    localparam logic [OP_W-1:0] OP_BASE = 10'h100;

    function automatic page_map_t lookup_page(page_t p);
        page_map_t m;
        m.can_switch = 1'b1;
        m.read_base  = 1'b0;
        m.grp        = GRP_P35;
        if (p[3]) begin
            m.grp = grp_e'(GRP_W'(PORT_GRP) + GRP_W'(p[2:1]));
        end else begin
            case (p[2:0])
                3'd3: m.read_base = 1'b1;
                3'd4: m.grp = GRP_P4;
                3'd5: m.grp = GRP_P35;
                3'd6: m.grp = GRP_P6;
                3'd7: m.grp = GRP_P7;
                default: begin
                    m.can_switch = 1'b0;
                    m.read_base  = 1'b1;
                end
            endcase
        end
        return m;
    endfunction

    function automatic op_dec_t decode_op(logic [OP_W-1:0] op);
        op_dec_t d;
        d.hit  = ((op & OP_MASK) == OP_BASE);
        d.code = {op[6], op[7]};
        return d;
    endfunction

endpackage

// File: rtl/gbank_op_decode.sv
module gbank_op_decode
    import gbank_pkg::*;
(
    input  logic            op_valid,
    input  logic [OP_W-1:0] op_code,
    output logic            op_hit,
    output bank_t           op_bank
);
    op_dec_t dec;

    always_comb begin
        dec     = decode_op(op_code);
        op_hit  = op_valid && dec.hit;
        op_bank = dec.code;
    end
endmodule

// File: rtl/gbank_page_map.sv
module gbank_page_map
    import gbank_pkg::*;
(
    input  page_t     page,
    output page_map_t pmap
);
    always_comb pmap = lookup_page(page);
endmodule

// File: rtl/gbank_state_file.sv
module gbank_state_file
    import gbank_pkg::*;
#(
    parameter int NG = N_GRP,
    parameter int GW = GRP_W
) (
    input  logic               clk,
    input  logic               rst,
    input  logic               clr_all,
    input  logic               upd_en,
    input  logic [GW-1:0]      upd_grp,
    input  bank_t              upd_bank,
    input  logic [GW-1:0]      rd_grp,
    output bank_t              rd_bank,
    output logic [NG*BANK_W-1:0] all_banks
);
    bank_t regs [NG];

    for (genvar g = 0; g < NG; g++) begin : g_grp
        always_ff @(posedge clk) begin
            if (rst || clr_all)
                regs[g] <= '0;
            else if (upd_en && upd_grp == GW'(g))
                regs[g] <= upd_bank;
        end
        assign all_banks[g*BANK_W +: BANK_W] = regs[g];
    end

    assign rd_bank = regs[rd_grp];
endmodule

// File: rtl/gbank_select.sv
module gbank_select
    import gbank_pkg::*;
#(
    parameter int ADDR_W = 16
) (
    input  logic                     clk,
    input  logic                     rst,
    input  logic [ADDR_W-1:0]        fetch_addr,
    input  logic                     op_valid,
    input  logic [OP_W-1:0]          op_code,
    input  logic                     sleep_req,
    output logic [BANK_W-1:0]        bank_idx,
    output logic [ADDR_W+BANK_W-1:0] bank_addr
);
    page_t     page;
    page_map_t pmap;
    logic      op_hit;
    bank_t     op_bank;
    logic      upd_en;
    bank_t     grp_rd;
    logic [N_GRP*BANK_W-1:0] grp_bank;

    assign page = fetch_addr[ADDR_W-1 -: PAGE_W];

    gbank_page_map u_map (
        .page (page),
        .pmap (pmap)
    );

    gbank_op_decode u_dec (
        .op_valid (op_valid),
        .op_code  (op_code),
        .op_hit   (op_hit),
        .op_bank  (op_bank)
    );

    assign upd_en = op_hit && pmap.can_switch;

    gbank_state_file #(.NG(N_GRP), .GW(GRP_W)) u_state (
        .clk       (clk),
        .rst       (rst),
        .clr_all   (sleep_req),
        .upd_en    (upd_en),
        .upd_grp   (pmap.grp),
        .upd_bank  (op_bank),
        .rd_grp    (pmap.grp),
        .rd_bank   (grp_rd),
        .all_banks (grp_bank)
    );

    assign bank_idx  = pmap.read_base ? '0 : grp_rd;
    assign bank_addr = {bank_idx, fetch_addr};
endmodule

// File: rtl/gbank_select_chk.sv
module gbank_select_chk
    import gbank_pkg::*;
#(
    parameter int ADDR_W = 16
) (
    input logic                     clk,
    input logic                     rst,
    input logic [ADDR_W-1:0]        fetch_addr,
    input logic                     op_valid,
    input logic                     sleep_req,
    input logic [BANK_W-1:0]        bank_idx,
    input logic [ADDR_W+BANK_W-1:0] bank_addr,
    input logic                     upd_en,
    input logic [GRP_W-1:0]         upd_grp,
    input logic [BANK_W-1:0]        upd_bank,
    input logic [N_GRP*BANK_W-1:0]  grp_bank
);
    logic [N_GRP*BANK_W-1:0] prev_bank;
    logic                    prev_sleep;
    logic                    prev_upd;
    logic [GRP_W-1:0]        prev_grp;
    logic [BANK_W-1:0]       prev_code;
    logic [N_GRP-1:0]        chg;

    always_ff @(posedge clk) begin
        prev_bank  <= grp_bank;
        prev_sleep <= sleep_req;
        prev_upd   <= upd_en;
        prev_grp   <= upd_grp;
        prev_code  <= upd_bank;
    end

    always_comb
        for (int g = 0; g < N_GRP; g++)
            chg[g] = (grp_bank[g*BANK_W +: BANK_W] != prev_bank[g*BANK_W +: BANK_W]);

    // R1, R2: operating-system pages read bank 1
    assert_os_base_R1: assert property (@(posedge clk) disable iff (rst)
        (fetch_addr[ADDR_W-1 -: PAGE_W] <= 4'h3) |-> (bank_idx == '0));

    // R5: no strobe means no state change
    assert_no_strobe_R5: assert property (@(posedge clk) disable iff (rst)
        (!op_valid && !sleep_req) |=> $stable(grp_bank));

    // R6: at most one group changes per cycle outside sleep
    assert_one_group_R6: assert property (@(posedge clk) disable iff (rst)
        !prev_sleep |-> $onehot0(chg));

    // R7: an accepted update is held the next cycle
    assert_update_lands_R7: assert property (@(posedge clk) disable iff (rst)
        (prev_upd && !prev_sleep) |-> (grp_bank[prev_grp*BANK_W +: BANK_W] == prev_code));

    // R8: sleep clears every group
    assert_sleep_clear_R8: assert property (@(posedge clk) disable iff (rst)
        sleep_req |=> (grp_bank == '0));

    // R9: reset clears every group
    assert_reset_clear_R9: assert property (@(posedge clk)
        rst |=> (grp_bank == '0));

    // R10: extended address carries the bank code
    assert_addr_concat_R10: assert property (@(posedge clk) disable iff (rst)
        bank_addr == {bank_idx, fetch_addr});
endmodule

bind gbank_select gbank_select_chk #(.ADDR_W(ADDR_W)) u_chk (
    .clk        (clk),
    .rst        (rst),
    .fetch_addr (fetch_addr),
    .op_valid   (op_valid),
    .sleep_req  (sleep_req),
    .bank_idx   (bank_idx),
    .bank_addr  (bank_addr),
    .upd_en     (upd_en),
    .upd_grp    (pmap.grp),
    .upd_bank   (op_bank),
    .grp_bank   (grp_bank)
);

// File: tb/test_gbank_select.sv
module test_gbank_select;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic [15:0] fetch_addr = '0;
    logic        op_valid = 1'b0;
    logic [9:0]  op_code = '0;
    logic        sleep_req = 1'b0;
    logic [1:0]  bank_idx;
    logic [17:0] bank_addr;

    int n_chk = 0;
    int n_err = 0;
    logic [1:0] exp_g [8];

    always #10 clk = ~clk;

    gbank_select i_gbank_select (
        .clk        (clk),
        .rst        (rst),
        .fetch_addr (fetch_addr),
        .op_valid   (op_valid),
        .op_code    (op_code),
        .sleep_req  (sleep_req),
        .bank_idx   (bank_idx),
        .bank_addr  (bank_addr)
    );

    // Group of a page per R1..R4; -1 for pages that never switch
    function automatic int grp_of(int p);
        if (p <= 2) return -1;
        if (p == 3 || p == 5) return 0;
        if (p == 4) return 1;
        if (p == 6) return 2;
        if (p == 7) return 3;
        return 4 + (p - 8) / 2;
    endfunction

    function automatic logic [1:0] exp_read(int p);
        if (p <= 3) return 2'b00;
        return exp_g[grp_of(p)];
    endfunction

    function automatic logic [1:0] op2code(logic [9:0] op);
        case (op)
            10'h100: return 2'b00;
            10'h180: return 2'b01;
            10'h140: return 2'b10;
            default: return 2'b11;
        endcase
    endfunction

    task automatic check(string req, logic [17:0] act, logic [17:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_err++;
            $display("FAIL %s: actual=%h expected=%h", req, act, exp);
        end
    endtask

    // at negedge, no strobe: read page p and compare
    task automatic peek(int p, string req);
        fetch_addr = {4'(p), 12'h5A3};
        op_valid   = 1'b0;
        sleep_req  = 1'b0;
        #1;
        check(req, {16'b0, bank_idx}, {16'b0, exp_read(p)});
    endtask

    task automatic sweep(string req);
        for (int p = 0; p < 16; p++) peek(p, req);
    endtask

    // fetch op from page p for one cycle; model update per R5
    task automatic fetch_op(int p, logic [9:0] op, bit slp);
        @(negedge clk);
        fetch_addr = {4'(p), 12'h0F0};
        op_valid   = 1'b1;
        op_code    = op;
        sleep_req  = slp;
        #1;
        // R7: old value still shown in opcode cycle
        check("R7", {16'b0, bank_idx}, {16'b0, exp_read(p)});
        @(posedge clk);
        #1;
        op_valid  = 1'b0;
        sleep_req = 1'b0;
        if (slp) begin
            for (int g = 0; g < 8; g++) exp_g[g] = 2'b00;
        end else if (grp_of(p) >= 0 &&
                     (op == 10'h100 || op == 10'h180 || op == 10'h140 || op == 10'h1C0)) begin
            exp_g[grp_of(p)] = op2code(op);
        end
        @(negedge clk);
    endtask

    task automatic t_reset;
        sweep("R9");
    endtask

    task automatic t_encoding;
        fetch_op(8, 10'h180, 0); peek(8, "R5"); peek(9, "R4");
        fetch_op(9, 10'h140, 0); peek(8, "R4"); peek(9, "R5");
        fetch_op(8, 10'h1C0, 0); peek(9, "R5");
        fetch_op(9, 10'h100, 0); peek(8, "R5");
    endtask

    task automatic t_pairs;
        fetch_op(4'hA, 10'h180, 0);
        fetch_op(4'hD, 10'h140, 0);
        fetch_op(4'hE, 10'h1C0, 0);
        sweep("R4");
    endtask

    task automatic t_os;
        for (int p = 0; p < 3; p++) fetch_op(p, 10'h1C0, 0);
        sweep("R1");
        check("R10", bank_addr, {exp_read(15), 4'hF, 12'h5A3});
    endtask

    task automatic t_link35;
        fetch_op(3, 10'h180, 0);
        peek(3, "R2"); peek(5, "R2");
        fetch_op(5, 10'h1C0, 0);
        peek(3, "R2"); peek(5, "R2");
    endtask

    task automatic t_standalone;
        fetch_op(4, 10'h140, 0);
        fetch_op(6, 10'h180, 0);
        fetch_op(7, 10'h1C0, 0);
        sweep("R3");
        fetch_op(6, 10'h100, 0);
        sweep("R6");
    endtask

    task automatic t_ignored;
        @(negedge clk);
        fetch_addr = 16'h4000; op_code = 10'h180; op_valid = 1'b0;
        @(negedge clk);
        peek(4, "R5");
        fetch_op(4, 10'h181, 0);
        fetch_op(4, 10'h300, 0);
        fetch_op(4, 10'h1A0, 0);
        sweep("R5");
    endtask

    task automatic t_sleep;
        fetch_op(8, 10'h1C0, 1);
        sweep("R8");
        fetch_op(4'hC, 10'h180, 0);
        peek(4'hD, "R6");
        fetch_op(7, 10'h140, 0);
        @(negedge clk);
        sleep_req = 1'b1;
        @(negedge clk);
        sleep_req = 1'b0;
        for (int g = 0; g < 8; g++) exp_g[g] = 2'b00;
        sweep("R8");
    endtask

    task automatic finish_run;
        $display("Result: errors=%0d of %0d checks", n_err, n_chk);
        $finish;
    endtask

    initial begin
        #(200000 * 20);
        n_err++;
        n_chk++;
        $display("FAIL watchdog: actual=timeout expected=done");
        finish_run();
    end

    initial begin
        for (int g = 0; g < 8; g++) exp_g[g] = 2'b00;
        repeat (3) @(posedge clk);
        @(negedge clk);
        rst = 1'b0;
        t_reset();
        t_encoding();
        t_pairs();
        t_os();
        t_link35();
        t_standalone();
        t_ignored();
        t_sleep();
        finish_run();
    end

endmodule